// File: doc/BRIEF.md
# Serial FPGA configuration sequencer

This block loads a configuration bitstream into a slave FPGA through five pins. It drives a program request, a configuration clock and a configuration data line. It watches two status lines from the slave: an init status and a done status. The bitstream arrives one byte at a time on a valid/ready stream, and a flag marks the final byte.

A start pulse begins a run. The block asserts the program request and waits for init to fall. It then releases the request and waits for init to rise again. Next it throws away incoming bytes until it has seen four 0xFF bytes in a row. From then on it sends every byte, starting with the first byte of those four. When the final byte has gone out, it waits for done. Each of the three waits has a timeout counted in coarse ticks, and the ticks come from a prescaler on the system clock. At the end of the run the block reports either success or one of three error codes. The result holds until the next start.

Top module: `fpga_cfg_seq`

## Requirements
- R1: When no run is active, cfg_clk and cfg_data are high, cfg_prog is at its inactive level and in_ready is low. busy is low after reset.
- R2: The program request is active-low when PROG_ACT_HIGH=0 (the default) and active-high when PROG_ACT_HIGH=1.
- R3: A start pulse while idle raises busy and asserts cfg_prog, with cfg_clk and cfg_data held high. cfg_prog stays asserted until cfg_init is seen low.
- R4: After cfg_init goes low, cfg_prog is released. in_ready stays low until cfg_init is seen high again.
- R5: Each wait times out when TIMEOUT_TICKS+1 ticks of TICK_DIV clocks go by without its condition. A timeout ends the run with busy low and err_code set to one of three values: 1 means init never fell, 2 means init never rose again, 3 means done never rose.
- R6: Bytes are discarded until four consecutive 0xFF bytes have been accepted. Any other byte restarts the count. Serial output begins with the first of those four 0xFF bytes.
- R7: Each byte goes out most significant bit first. Each bit uses four phases of PHASE_CLKS clocks each: clock low with data high, data set to the bit, clock high, data high again. So cfg_data holds the bit at each rising edge of cfg_clk, and cfg_clk stays low for 2*PHASE_CLKS clocks before each rise.
- R8: After the byte flagged in_last has been sent, the block waits for cfg_done. When cfg_done is seen high, the run ends with ok=1 and err_code=0.
- R9: A start pulse while busy is ignored, and the run in progress continues unchanged.
- R10: ok and err_code hold their values until the next accepted start, which clears both of them. ok is never 1 while err_code is nonzero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Pulse that begins a configuration run |
| in_data | input | 8 | Bitstream byte |
| in_valid | input | 1 | in_data holds a byte |
| in_last | input | 1 | This byte is the final byte of the bitstream |
| in_ready | output | 1 | The block accepts the byte in this cycle |
| cfg_prog | output | 1 | Program request pin to the slave |
| cfg_clk | output | 1 | Configuration clock pin |
| cfg_data | output | 1 | Configuration data pin |
| cfg_init | input | 1 | Init status from the slave |
| cfg_done | input | 1 | Done status from the slave |
| busy | output | 1 | A run is in progress |
| ok | output | 1 | The last run ended successfully |
| err_code | output | 2 | 0 none, 1 init stuck high, 2 init stuck low, 3 done timeout |

## Verification
The hardest stimulus to produce from the ports is a preamble hunt that almost matches and then has to restart. The stream in the test contains a pair of 0xFF bytes cut off by another value, and only after that a true run of four. This checks that the partial match is dropped and that the first bit on the wire belongs to the first 0xFF of the real preamble. The three timeouts each need the slave model to hold one status pin at the wrong level for more than the tick window. The bench does this by steering cfg_init and cfg_done step by step, checking both before and after the deadline. It also pulses start in the middle of serialization, so the scoreboard can show that the bit stream continues unbroken.

// File: rtl/fpga_cfg_pkg.sv
package fpga_cfg_pkg;
  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_PROG  = 3'd1,
    ST_WINIT = 3'd2,
    ST_HUNT  = 3'd3,
    ST_SEND  = 3'd4,
    ST_WDONE = 3'd5
  } cfg_state_e;

  localparam logic [1:0] ERR_NONE      = 2'd0;
  localparam logic [1:0] ERR_INIT_HIGH = 2'd1;
  localparam logic [1:0] ERR_INIT_LOW  = 2'd2;
  localparam logic [1:0] ERR_DONE      = 2'd3;

  localparam int unsigned SYNC_LEN = 4;
  localparam logic [7:0]  SYNC_BYTE = 8'hFF;
endpackage

// File: rtl/cfg_tick.sv
module cfg_tick #(
  parameter int unsigned TICK_DIV = 250000
) (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  output logic tick
);
  localparam int unsigned CW = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;
  localparam logic [CW-1:0] TOP = CW'(TICK_DIV - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      cnt  <= '0;
      tick <= 1'b0;
    end else if (cnt == TOP) begin
      cnt  <= '0;
      tick <= 1'b1;
    end else begin
      cnt  <= cnt + 1'b1;
      tick <= 1'b0;
    end
  end
endmodule

// File: rtl/cfg_shift.sv
module cfg_shift #(
  parameter int unsigned PHASE_CLKS = 4
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       load,
  input  logic [7:0] byte_in,
  output logic       busy,
  output logic       pin_clk,
  output logic       pin_data
);
  localparam int unsigned PW = (PHASE_CLKS > 1) ? $clog2(PHASE_CLKS) : 1;
  localparam logic [PW-1:0] PTOP = PW'(PHASE_CLKS - 1);

  logic [7:0]    sr;
  logic [2:0]    bitn;
  logic [1:0]    ph;
  logic [PW-1:0] pc;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy <= 1'b0;
      sr   <= '0;
      bitn <= '0;
      ph   <= '0;
      pc   <= '0;
    end else if (!busy) begin
      if (load) begin
        busy <= 1'b1;
        sr   <= byte_in;
        bitn <= 3'd7;
        ph   <= 2'd0;
        pc   <= '0;
      end
    end else if (pc != PTOP) begin
      pc <= pc + 1'b1;
    end else begin
      pc <= '0;
      if (ph != 2'd3) begin
        ph <= ph + 2'd1;
      end else begin
        ph <= 2'd0;
        if (bitn == 3'd0) begin
          busy <= 1'b0;
        end else begin
          bitn <= bitn - 3'd1;
          sr   <= {sr[6:0], 1'b0};
        end
      end
    end
  end

  always_comb begin
    pin_clk  = !busy || ph[1];
    pin_data = (busy && (ph == 2'd1 || ph == 2'd2)) ? sr[7] : 1'b1;
  end

  // R7: data is already in place when the clock rises
  p_setup_before_rise_r7: assert property (@(posedge clk) disable iff (rst)
    (busy && $rose(pin_clk)) |-> (pin_data == $past(pin_data)));
endmodule

// File: rtl/fpga_cfg_seq.sv
module fpga_cfg_seq
  import fpga_cfg_pkg::*;
#(
  parameter int unsigned TICK_DIV      = 250000,
  parameter int unsigned TIMEOUT_TICKS = 3,
  parameter int unsigned PHASE_CLKS    = 4,
  parameter bit          PROG_ACT_HIGH = 1'b0
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       start,
  input  logic [7:0] in_data,
  input  logic       in_valid,
  input  logic       in_last,
  output logic       in_ready,
  output logic       cfg_prog,
  output logic       cfg_clk,
  output logic       cfg_data,
  input  logic       cfg_init,
  input  logic       cfg_done,
  output logic       busy,
  output logic       ok,
  output logic [1:0] err_code
);
  localparam int unsigned TW = $clog2(TIMEOUT_TICKS + 1) + 1;
  localparam logic [TW-1:0] TLIM = TW'(TIMEOUT_TICKS);
  localparam int unsigned SW = $clog2(SYNC_LEN) + 1;
  localparam logic [SW-1:0] SLAST = SW'(SYNC_LEN - 1);
  localparam logic PROG_IDLE = !PROG_ACT_HIGH;

  cfg_state_e state, state_n;
  logic init_q, done_q, tick, timeout, tclr;
  logic [TW-1:0] tcnt;
  logic [SW-1:0] ff_cnt, pre_left;
  logic last_seen;
  logic sh_busy, sh_load, sh_clk, sh_data;
  logic [7:0] sh_byte;
  logic accept, is_sync;

  cfg_tick #(.TICK_DIV(TICK_DIV)) u_tick (
    .clk(clk), .rst(rst), .clr(tclr), .tick(tick)
  );

  cfg_shift #(.PHASE_CLKS(PHASE_CLKS)) u_shift (
    .clk(clk), .rst(rst), .load(sh_load), .byte_in(sh_byte),
    .busy(sh_busy), .pin_clk(sh_clk), .pin_data(sh_data)
  );

  assign is_sync = (in_data == SYNC_BYTE);
  assign timeout = tick && (tcnt == TLIM);
  assign tclr    = (state_n != state);
  assign busy    = (state != ST_IDLE);

  always_comb begin
    in_ready = 1'b0;
    if (state == ST_HUNT) in_ready = 1'b1;
    else if (state == ST_SEND && !sh_busy && pre_left == '0 && !last_seen)
      in_ready = 1'b1;
  end
  assign accept = in_ready && in_valid;

  always_comb begin
    sh_load = 1'b0;
    sh_byte = in_data;
    if (state == ST_HUNT) begin
      sh_load = accept && is_sync && (ff_cnt == SLAST);
      sh_byte = SYNC_BYTE;
    end else if (state == ST_SEND && !sh_busy) begin
      if (pre_left != '0) begin
        sh_load = 1'b1;
        sh_byte = SYNC_BYTE;
      end else begin
        sh_load = accept;
      end
    end
  end

  always_comb begin
    state_n = state;
    unique case (state)
      ST_IDLE:  if (start) state_n = ST_PROG;
      ST_PROG:  if (!init_q) state_n = ST_WINIT;
                else if (timeout) state_n = ST_IDLE;
      ST_WINIT: if (init_q) state_n = ST_HUNT;
                else if (timeout) state_n = ST_IDLE;
      ST_HUNT:  if (sh_load) state_n = ST_SEND;
      ST_SEND:  if (!sh_busy && pre_left == '0 && last_seen) state_n = ST_WDONE;
      ST_WDONE: if (done_q || timeout) state_n = ST_IDLE;
      default:  state_n = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      init_q    <= 1'b1;
      done_q    <= 1'b0;
      tcnt      <= '0;
      ff_cnt    <= '0;
      pre_left  <= '0;
      last_seen <= 1'b0;
      ok        <= 1'b0;
      err_code  <= ERR_NONE;
      cfg_prog  <= PROG_IDLE;
      cfg_clk   <= 1'b1;
      cfg_data  <= 1'b1;
    end else begin
      state  <= state_n;
      init_q <= cfg_init;
      done_q <= cfg_done;
      if (tclr) tcnt <= '0;
      else if (tick) tcnt <= tcnt + 1'b1;

      cfg_prog <= (state_n == ST_PROG) ? !PROG_IDLE : PROG_IDLE;
      cfg_clk  <= sh_clk;
      cfg_data <= sh_data;

      if (state == ST_IDLE && start) begin
        ok        <= 1'b0;
        err_code  <= ERR_NONE;
        ff_cnt    <= '0;
        pre_left  <= '0;
        last_seen <= 1'b0;
      end
      if (state == ST_PROG && init_q && timeout) err_code <= ERR_INIT_HIGH;
      if (state == ST_WINIT && !init_q && timeout) err_code <= ERR_INIT_LOW;
      if (state == ST_WDONE) begin
        if (done_q) ok <= 1'b1;
        else if (timeout) err_code <= ERR_DONE;
      end

      if (state == ST_HUNT && accept) begin
        if (!is_sync) ff_cnt <= '0;
        else if (ff_cnt != SLAST) ff_cnt <= ff_cnt + 1'b1;
        else begin
          pre_left  <= SLAST;
          last_seen <= in_last;
        end
      end
      if (state == ST_SEND && !sh_busy) begin
        if (pre_left != '0) pre_left <= pre_left - 1'b1;
        else if (accept) last_seen <= in_last;
      end
    end
  end

  // R1: quiet pins once a run has been over for a cycle
  p_idle_pins_r1: assert property (@(posedge clk) disable iff (rst)
    (!busy && $past(!busy)) |-> (cfg_clk && cfg_data && cfg_prog == PROG_IDLE && !in_ready));
  // R9: start during a run never ends it
  p_start_ignored_r9: assert property (@(posedge clk) disable iff (rst)
    (busy && start && state != ST_WDONE && state != ST_PROG && state != ST_WINIT) |=> busy);
  // R10: success and error are exclusive
  p_ok_err_excl_r10: assert property (@(posedge clk) disable iff (rst)
    !(ok && err_code != ERR_NONE));
  // R4: no byte taken before init has come back
  p_no_data_early_r4: assert property (@(posedge clk) disable iff (rst)
    (state == ST_PROG || state == ST_WINIT) |-> !in_ready);
  // R3: program request asserted on the cycle after a run starts
  p_prog_on_start_r3: assert property (@(posedge clk) disable iff (rst)
    (state == ST_IDLE && start) |=> (cfg_prog == !PROG_IDLE));
endmodule

// File: tb/fpga_cfg_seq_tb.sv
module fpga_cfg_seq_tb;
  localparam int TICK_DIV = 16;
  localparam int TMO = 3;
  localparam int PH = 2;
  localparam int WINDOW = (TMO + 1) * TICK_DIV;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start = 1'b0;
  logic [7:0] in_data = '0;
  logic in_valid = 1'b0, in_last = 1'b0;
  logic in_ready, cfg_prog, cfg_clk, cfg_data, busy, ok;
  logic cfg_init = 1'b1, cfg_done = 1'b0;
  logic [1:0] err_code;

  int vectors = 0, miscompares = 0;
  bit exp_bits[$];
  logic [7:0] stream[$];
  logic prev_clk = 1'b1;
  int lowcnt = 0;
  bit done_flag = 1'b0;

  always #2 clk = ~clk;

  fpga_cfg_seq #(.TICK_DIV(TICK_DIV), .TIMEOUT_TICKS(TMO), .PHASE_CLKS(PH)) u_dut (
    .clk(clk), .rst(rst), .start(start), .in_data(in_data), .in_valid(in_valid),
    .in_last(in_last), .in_ready(in_ready), .cfg_prog(cfg_prog), .cfg_clk(cfg_clk),
    .cfg_data(cfg_data), .cfg_init(cfg_init), .cfg_done(cfg_done), .busy(busy),
    .ok(ok), .err_code(err_code)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // monitor: pops expected bits at each rising edge of cfg_clk
  always @(negedge clk) begin
    if (!rst) begin
      if (!cfg_clk) lowcnt++;
      if (cfg_clk && !prev_clk) begin
        if (exp_bits.size() == 0) chk("R6 unexpected bit", 8'd1, 8'd0);
        else chk("R7 bit value", {7'd0, cfg_data}, {7'd0, exp_bits.pop_front()});
        chk("R7 clock low width", 8'(lowcnt), 8'(2 * PH));
        lowcnt = 0;
      end
    end
    prev_clk = cfg_clk;
  end

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse_start();
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
  endtask

  // driver: computes the expected bit sequence and feeds the stream
  task automatic drive_stream();
    int ffc = 0;
    bit on = 0;
    for (int i = 0; i < stream.size(); i++) begin
      if (!on) begin
        if (stream[i] == 8'hFF) ffc++; else ffc = 0;
        if (ffc == 4) begin
          on = 1;
          for (int k = 0; k < 32; k++) exp_bits.push_back(1'b1);
        end
      end else begin
        for (int b = 7; b >= 0; b--) exp_bits.push_back(stream[i][b]);
      end
    end
    for (int i = 0; i < stream.size(); i++) begin
      @(negedge clk);
      in_data = stream[i]; in_valid = 1'b1; in_last = (i == stream.size() - 1);
      while (1) begin
        if (in_ready) begin @(posedge clk); break; end
        @(negedge clk);
      end
    end
    @(negedge clk) in_valid = 1'b0; in_last = 1'b0;
  endtask

  task automatic handshake();
    pulse_start();
    cyc(3);
    chk("R3 busy", {7'd0, busy}, 8'd1);
    chk("R2 prog active-low", {7'd0, cfg_prog}, 8'd0);
    chk("R3 clk/data high", {6'd0, cfg_clk, cfg_data}, 8'd3);
    cyc(10);
    chk("R3 prog held", {7'd0, cfg_prog}, 8'd0);
    cfg_init = 1'b0;
    cyc(4);
    chk("R4 prog released", {7'd0, cfg_prog}, 8'd1);
    chk("R4 no ready while init low", {7'd0, in_ready}, 8'd0);
    cyc(20);
    cfg_init = 1'b1;
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    miscompares++;
    vectors++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    cyc(4);
    @(negedge clk) rst = 1'b0;
    cyc(2);
    chk("R1 reset busy", {7'd0, busy}, 8'd0);
    chk("R1 reset pins", {5'd0, cfg_prog, cfg_clk, cfg_data}, 8'h7);
    chk("R1 reset ready", {7'd0, in_ready}, 8'd0);

    // normal run with a false partial preamble
    handshake();
    stream = '{8'h12, 8'hFF, 8'hFF, 8'h34, 8'hFF, 8'hFF, 8'hFF, 8'hFF, 8'hA5, 8'h3C, 8'h81};
    fork
      drive_stream();
      begin cyc(200); pulse_start(); end
    join
    while (exp_bits.size() != 0 && busy) cyc(1);
    chk("R9 still busy after stray start", {7'd0, busy}, 8'd1);
    chk("R6 all bits sent", 8'(exp_bits.size()), 8'd0);
    cyc(5);
    chk("R8 waiting for done", {7'd0, busy}, 8'd1);
    cfg_done = 1'b1;
    cyc(4);
    chk("R8 ok", {7'd0, ok}, 8'd1);
    chk("R8 err none", {6'd0, err_code}, 8'd0);
    chk("R1 idle after run", {5'd0, busy, cfg_clk, cfg_data}, 8'h3);
    cfg_done = 1'b0;

    // init never falls
    pulse_start();
    cyc(2);
    chk("R10 ok cleared on start", {7'd0, ok}, 8'd0);
    cyc(WINDOW - 20);
    chk("R5 not yet timed out", {6'd0, err_code}, 8'd0);
    cyc(40);
    chk("R5 init high timeout", {6'd0, err_code}, 8'd1);
    chk("R5 busy dropped", {7'd0, busy}, 8'd0);
    chk("R1 prog inactive after fail", {7'd0, cfg_prog}, 8'd1);
    cyc(10);
    chk("R10 err held", {6'd0, err_code}, 8'd1);

    // init never rises again
    pulse_start();
    cyc(2);
    chk("R10 err cleared on start", {6'd0, err_code}, 8'd0);
    cfg_init = 1'b0;
    cyc(WINDOW + 40);
    chk("R5 init low timeout", {6'd0, err_code}, 8'd2);
    cfg_init = 1'b1;
    cyc(4);

    // done never rises; preamble is also the last data
    handshake();
    stream = '{8'h00, 8'hFF, 8'hFF, 8'hFF, 8'hFF};
    drive_stream();
    while (exp_bits.size() != 0 && busy) cyc(1);
    chk("R6 preamble-only bits", 8'(exp_bits.size()), 8'd0);
    cyc(WINDOW - 20);
    chk("R8 still waiting", {7'd0, busy}, 8'd1);
    cyc(50);
    chk("R5 done timeout", {6'd0, err_code}, 8'd3);
    chk("R10 ok low on error", {7'd0, ok}, 8'd0);

    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule